// File: doc/BRIEF.md
# Streaming Text Matrix Parser

This block takes the byte stream coming out of a serial receiver and turns a plain-text matrix of unsigned decimal numbers into binary words. Each byte arrives with a one-cycle valid strobe. Digits are folded into a running binary value as they come in, so no character buffer is kept. When a delimiter closes a number, the value goes out on a simple write port. The port carries an enable, an address and a data word, and fills an external memory in row-major order starting at address zero.

The block learns the matrix shape without being told it. Values are counted across a line to give the column count, which is taken from the first non-empty row. Each non-empty line adds one row. When the end-of-transmission code arrives, the block flushes any pending value and counts an unterminated last row. It then raises a done flag and holds the dimensions until reset or a clear pulse.

Malformed text is flagged rather than rejected. A byte of an unknown kind, or a row whose length differs from the first row, sets a sticky format-error flag.

Top module: `mtx_text_parser`

## Requirements
- R1: Digit bytes 0x30..0x39 build a decimal value. The value is written out when a delimiter (space 0x20, tab 0x09, comma 0x2C, LF 0x0A or end-of-transmission 0x04) follows at least one digit.
- R2: A delimiter with no digits before it, including repeated or leading delimiters, produces no write and leaves the counts unchanged.
- R3: A value larger than 2^DATA_W-1 is written as 2^DATA_W-1, with no wrap-around.
- R4: Each accepted byte that ends a value asserts wr_en for exactly one cycle, one clock after the byte is accepted. wr_addr starts at 0 after reset or clear and rises by one for each write.
- R5: LF ends a pending value and closes the row. The column count is taken from the first row that holds at least one value, and rows counts each such row. A line with no values changes nothing.
- R6: CR (0x0D) has no effect on the outputs.
- R7: Byte 0x04 flushes a pending value and counts an unterminated last row. It also sets done. While done is high, input bytes are ignored, and rows and cols stay stable.
- R8: A row whose value count differs from the latched column count sets fmt_err, which stays set until reset or clear.
- R9: Any other byte value sets fmt_err and leaves the pending value unchanged, so digits on both sides of it join into one number.
- R10: Reset or clear drives wr_en, wr_addr, rows, cols, done and fmt_err to zero, and the next write goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous restart of parsing and counters |
| in_valid | input | 1 | in_byte holds a received character this cycle |
| in_byte | input | 8 | Received character |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Row-major word address |
| wr_data | output | DATA_W | Converted value |
| rows | output | DIM_W | Rows seen so far |
| cols | output | DIM_W | Column count latched from the first row |
| done | output | 1 | End of transmission seen |
| fmt_err | output | 1 | Sticky malformed-text flag |

## Verification
A byte accepted at a rising edge shows its write one edge later. The same edge updates rows, cols, done and fmt_err, so every result is due in the cycle right after its byte. The bench drives bytes on falling edges and captures writes on the next falling edge, which is half a cycle after the register update. It compares each captured address against a running count. The dimension and flag checks come two idle cycles after the end code, when nothing can still be in flight.

// File: rtl/mtx_parse_pkg.sv
package mtx_parse_pkg;

    typedef enum logic [2:0] {
        CK_DIGIT,
        CK_SEP,
        CK_LF,
        CK_CR,
        CK_EOT,
        CK_BAD
    } char_kind_e;

    typedef struct packed {
        char_kind_e kind;
        logic [3:0] digit;
    } char_info_t;

    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_NINE  = 8'h39;
    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_TAB   = 8'h09;
    localparam logic [7:0] CH_COMMA = 8'h2C;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_EOT   = 8'h04;

    function automatic char_info_t classify(input logic [7:0] b);
        char_info_t r;
        r.digit = b[3:0];
        if (b >= CH_ZERO && b <= CH_NINE)
            r.kind = CK_DIGIT;
        else if (b == CH_SPACE || b == CH_TAB || b == CH_COMMA)
            r.kind = CK_SEP;
        else if (b == CH_LF)
            r.kind = CK_LF;
        else if (b == CH_CR)
            r.kind = CK_CR;
        else if (b == CH_EOT)
            r.kind = CK_EOT;
        else
            r.kind = CK_BAD;
        return r;
    endfunction

    function automatic logic ends_value(input char_kind_e k);
        return (k == CK_SEP) || (k == CK_LF) || (k == CK_EOT);
    endfunction

    function automatic logic ends_row(input char_kind_e k);
        return (k == CK_LF) || (k == CK_EOT);
    endfunction

endpackage

// File: rtl/mtx_char_class.sv
module mtx_char_class
    import mtx_parse_pkg::*;
(
    input  logic [7:0] byte_i,
    output char_info_t info_o
);
    always_comb begin
        info_o = classify(byte_i);
    end
endmodule

// File: rtl/mtx_dec_accum.sv
module mtx_dec_accum #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [3:0]        digit,
    input  logic              flush,
    output logic [DATA_W-1:0] value,
    output logic              pending
);
    localparam int WIDE_W = DATA_W + 4;
    localparam logic [DATA_W-1:0] VAL_MAX = '1;

    logic [DATA_W-1:0] acc_q;
    logic              pend_q;
    logic [WIDE_W-1:0] acc_wide;
    logic [WIDE_W-1:0] next_wide;
    logic [DATA_W-1:0] next_sat;

    always_comb begin
        acc_wide  = {4'b0000, acc_q};
        next_wide = (acc_wide << 3) + (acc_wide << 1) + {{DATA_W{1'b0}}, digit};
        if (next_wide > {4'b0000, VAL_MAX})
            next_sat = VAL_MAX;
        else
            next_sat = next_wide[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            pend_q <= 1'b0;
        end else if (flush) begin
            acc_q  <= '0;
            pend_q <= 1'b0;
        end else if (step) begin
            acc_q  <= next_sat;
            pend_q <= 1'b1;
        end
    end

    assign value   = acc_q;
    assign pending = pend_q;
endmodule

// File: rtl/mtx_dim_track.sv
module mtx_dim_track #(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             val_end,
    input  logic             row_end,
    output logic [DIM_W-1:0] rows,
    output logic [DIM_W-1:0] cols,
    output logic             shape_err
);
    logic [DIM_W-1:0] col_cnt_q;
    logic [DIM_W-1:0] row_cnt_q;
    logic [DIM_W-1:0] cols_q;
    logic             first_seen_q;
    logic             err_q;
    logic [DIM_W-1:0] cnt_now;

    assign cnt_now = col_cnt_q + DIM_W'(val_end);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col_cnt_q    <= '0;
            row_cnt_q    <= '0;
            cols_q       <= '0;
            first_seen_q <= 1'b0;
            err_q        <= 1'b0;
        end else if (row_end) begin
            col_cnt_q <= '0;
            if (cnt_now != '0) begin
                row_cnt_q <= row_cnt_q + 1'b1;
                if (!first_seen_q) begin
                    cols_q       <= cnt_now;
                    first_seen_q <= 1'b1;
                end else if (cnt_now != cols_q) begin
                    err_q <= 1'b1;
                end
            end
        end else if (val_end) begin
            col_cnt_q <= cnt_now;
        end
    end

    assign rows      = row_cnt_q;
    assign cols      = cols_q;
    assign shape_err = err_q;
endmodule

// File: rtl/mtx_text_parser.sv
module mtx_text_parser
    import mtx_parse_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DIM_W-1:0]  rows,
    output logic [DIM_W-1:0]  cols,
    output logic              done,
    output logic              fmt_err
);
    char_info_t        info;
    logic              accept;
    logic              is_digit;
    logic              delim;
    logic              val_end;
    logic              row_end;
    logic [DATA_W-1:0] acc_val;
    logic              acc_pending;
    logic              shape_err;

    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;
    logic [ADDR_W-1:0] addr_next_q;
    logic              done_q;
    logic              bad_q;

    mtx_char_class u_class (
        .byte_i (in_byte),
        .info_o (info)
    );

    assign accept   = in_valid && !done_q;
    assign is_digit = accept && (info.kind == CK_DIGIT);
    assign delim    = accept && ends_value(info.kind);
    assign val_end  = delim && acc_pending;
    assign row_end  = accept && ends_row(info.kind);

    mtx_dec_accum #(.DATA_W(DATA_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .step    (is_digit),
        .digit   (info.digit),
        .flush   (delim),
        .value   (acc_val),
        .pending (acc_pending)
    );

    mtx_dim_track #(.DIM_W(DIM_W)) u_dims (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .val_end   (val_end),
        .row_end   (row_end),
        .rows      (rows),
        .cols      (cols),
        .shape_err (shape_err)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_en_q     <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
            addr_next_q <= '0;
            done_q      <= 1'b0;
            bad_q       <= 1'b0;
        end else begin
            wr_en_q <= val_end;
            if (val_end) begin
                wr_data_q   <= acc_val;
                wr_addr_q   <= addr_next_q;
                addr_next_q <= addr_next_q + 1'b1;
            end
            if (accept && info.kind == CK_EOT)
                done_q <= 1'b1;
            if (accept && info.kind == CK_BAD)
                bad_q <= 1'b1;
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign done    = done_q;
    assign fmt_err = bad_q || shape_err;
endmodule

// File: rtl/mtx_parser_chk.sv
module mtx_parser_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clear,
    input logic              in_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DIM_W-1:0]  rows,
    input logic [DIM_W-1:0]  cols,
    input logic              done,
    input logic              fmt_err
);
    logic [ADDR_W-1:0] n_wr;

    always_ff @(posedge clk) begin
        if (rst || clear)
            n_wr <= '0;
        else if (wr_en)
            n_wr <= n_wr + 1'b1;
    end

    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr == n_wr); // R4

    AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(in_valid)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> done); // R7

    AST_DIMS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> ($stable(rows) && $stable(cols))); // R7

    AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> !wr_en); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fmt_err && !clear) |=> fmt_err); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!wr_en && !done && !fmt_err && rows == '0 && cols == '0)); // R10
endmodule

bind mtx_text_parser mtx_parser_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DIM_W  (DIM_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .in_valid (in_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rows     (rows),
    .cols     (cols),
    .done     (done),
    .fmt_err  (fmt_err)
);

// File: tb/mtx_text_parser_tb_top.sv
`timescale 1ns/1ps
module mtx_text_parser_tb_top;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int DIM_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clear = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DIM_W-1:0]  rows;
    logic [DIM_W-1:0]  cols;
    logic              done;
    logic              fmt_err;

    int total = 0;
    int fails = 0;
    int cap_data [0:1023];
    int cap_n = 0;
    int cap_base = 0;
    int addr_total = 0;
    int addr_fails = 0;

    always #5 clk = ~clk;

    mtx_text_parser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) dut_i (
        .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rows(rows), .cols(cols), .done(done), .fmt_err(fmt_err)
    );

    // R4: every captured write must carry the next address in sequence
    always @(negedge clk) begin
        if (wr_en) begin
            addr_total++;
            if (int'(wr_addr) != cap_n - cap_base) begin
                addr_fails++;
                $display("FAIL R4 address: actual %0d expected %0d", wr_addr, cap_n - cap_base);
            end
            cap_data[cap_n % 1024] = int'(wr_data);
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", (total + addr_total) - (fails + addr_fails), total + addr_total);
        $finish;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_num(input int v);
        int d [10];
        int n = 0;
        int x = v;
        do begin
            d[n] = x % 10;
            x = x / 10;
            n++;
        end while (x > 0);
        for (int i = n - 1; i >= 0; i--) send(8'(8'h30 + d[i]));
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        cap_base = cap_n;
    endtask

    function automatic int mval(input int nr, input int nc, input int r, input int c);
        return (r * 431 + c * 97 + nr * 13 + nc * 3) % 5000;
    endfunction

    function automatic logic [7:0] sep_of(input int k);
        case (k % 3)
            0: return 8'h20;
            1: return 8'h09;
            default: return 8'h2C;
        endcase
    endfunction

    task automatic check_vals(input string req, input int exp [], input int n);
        chk(cap_n - cap_base == n, {req, " write count"}, cap_n - cap_base, n);
        for (int i = 0; i < n && i < cap_n - cap_base; i++)
            chk(cap_data[(cap_base + i) % 1024] == exp[i], {req, " value"}, cap_data[(cap_base + i) % 1024], exp[i]);
    endtask

    task automatic run_matrix(input int nr, input int nc);
        int exp [];
        do_clear();
        chk(rows == 0 && cols == 0 && !done && !fmt_err && !wr_en, "R10 after clear", int'(rows) + int'(cols), 0);
        exp = new[nr * nc];
        for (int r = 0; r < nr; r++) begin
            if (r % 2 == 1) send(8'h20);             // R2 leading separator
            for (int c = 0; c < nc; c++) begin
                exp[r * nc + c] = mval(nr, nc, r, c);
                send_num(exp[r * nc + c]);
                if (c < nc - 1) begin
                    send(sep_of(r + c));
                    if (c % 2 == 1) send(8'h20);     // R2 repeated separator
                end
            end
            if (r < nr - 1 || ((nr + nc) % 2 == 0)) begin
                if (r % 2 == 1) send(8'h0D);         // R6 CR ignored
                send(8'h0A);
            end
        end
        send(8'h04);
        idle(2);
        check_vals("R1", exp, nr * nc);
        chk(int'(rows) == nr, "R5/R7 rows", rows, nr);
        chk(int'(cols) == nc, "R5 cols", cols, nc);
        chk(done == 1'b1, "R7 done", done, 1);
        chk(fmt_err == 1'b0, "R2/R6 no error", fmt_err, 0);
    endtask

    initial begin
        #1000000;
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e [];
        @(negedge clk);
        idle(3);
        chk(!wr_en && !done && !fmt_err && rows == 0 && cols == 0 && wr_addr == 0,
            "R10 reset state", int'(wr_en) + int'(done) + int'(rows), 0);
        rst = 1'b0;
        idle(1);

        for (int nr = 1; nr <= 4; nr++)
            for (int nc = 1; nc <= 5; nc++)
                run_matrix(nr, nc);

        // R3 saturation
        do_clear();
        send_num(99999); send(8'h2C);
        send_num(65535); send(8'h2C);
        send_num(65536); send(8'h2C);
        send_num(0);     send(8'h0A);
        send(8'h04);
        idle(2);
        e = new[4];
        e[0] = 65535; e[1] = 65535; e[2] = 65535; e[3] = 0;
        check_vals("R3", e, 4);
        chk(int'(cols) == 4, "R3 cols", cols, 4);

        // R7 input ignored after done
        send_num(7); send(8'h20); send_num(8); send(8'h0A);
        idle(2);
        chk(cap_n - cap_base == 4, "R7 no write after done", cap_n - cap_base, 4);
        chk(int'(rows) == 1 && int'(cols) == 4, "R7 dims held", rows, 1);

        // R8 row length mismatch
        do_clear();
        chk(!fmt_err && !done, "R10 clear", done, 0);
        send_num(1); send(8'h20); send_num(2); send(8'h0A);
        send_num(3); send(8'h0A);
        send(8'h04);
        idle(2);
        e = new[3];
        e[0] = 1; e[1] = 2; e[2] = 3;
        check_vals("R8", e, 3);
        chk(fmt_err == 1'b1, "R8 error set", fmt_err, 1);
        chk(int'(rows) == 2 && int'(cols) == 2, "R8 dims", rows, 2);

        // R9 illegal byte joins digits
        do_clear();
        chk(fmt_err == 1'b0, "R10 clear err", fmt_err, 0);
        send_num(1); send(8'h78); send_num(2); send(8'h20); send_num(3); send(8'h0A);
        send(8'h04);
        idle(2);
        e = new[2];
        e[0] = 12; e[1] = 3;
        check_vals("R9", e, 2);
        chk(fmt_err == 1'b1, "R9 error set", fmt_err, 1);
        chk(int'(cols) == 2, "R9 cols", cols, 2);

        // R5 empty lines
        do_clear();
        send(8'h0A); send(8'h0A);
        send_num(5); send(8'h20); send_num(6); send(8'h0A);
        send(8'h0A);
        send(8'h04);
        idle(2);
        e = new[2];
        e[0] = 5; e[1] = 6;
        check_vals("R5", e, 2);
        chk(int'(rows) == 1 && int'(cols) == 2, "R5 empty lines", rows, 1);
        chk(fmt_err == 1'b0, "R5 no error", fmt_err, 0);

        finish_run();
    end
endmodule